// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a data cache and tracks which cache lines are currently reserved by a load-linked access, and by which requester. When a store-conditional completes, the block decides whether it may take effect. The one-bit verdict returns to the core one cycle later. The block forgets a reservation in four cases: a store-conditional to the line, an ordinary store from the owning requester, a loss of coherence permission on the line, or eviction by a newer reservation when every slot is in use.

Every cache access that completes is presented on the completion port as a kind, a line address and a requester ID. Permission losses arrive on a separate invalidation port that may fire in the same cycle. A mode input lets the core run without the monitor's judgement. In that mode every store-conditional passes, while reservations keep being tracked. The coherence protocol, the tags and the data path live elsewhere.

Top module: `llsc_monitor`

## Requirements
- R1: A completion of kind 2'b01 (load-linked) always creates a reservation for its line, owned by its requester ID, and resv_count_o counts it from the next cycle.
- R2: A completion of kind 2'b10 (store-conditional) passes only when its line holds a reservation owned by the same requester ID. sc_done_o is high for exactly the one cycle after each store-conditional completion and low otherwise.
- R3: The verdict appears on sc_ok_o together with sc_done_o: 1 means the store-conditional passed, 0 means it failed. sc_ok_o is never high without sc_done_o.
- R4: Every store-conditional removes any reservation on its line, whether it passed or failed.
- R5: A completion of kind 2'b11 (ordinary store) removes the reservation on its line only when that reservation is owned by the same requester ID. A store from any other requester leaves it intact.
- R6: An invalidation (inv_valid_i with inv_line_i) removes any reservation on that line.
- R7: A load-linked to one line leaves the reservations on other lines in place.
- R8: When a store-conditional and a clearing event for the same line meet in one cycle, the verdict uses the reservation as it was before that cycle, and the clear then takes effect.
- R9: Up to SLOTS lines can be reserved at once. A load-linked to a new line when all slots are occupied replaces the reservation that was set or renewed longest ago.
- R10: While bypass_i is 1, every store-conditional reports sc_ok_o = 1. Reservation tracking continues unchanged.
- R11: A completion of kind 2'b00 (plain load) has no effect on any reservation.
- R12: A load-linked to an already reserved line hands the reservation to the new requester and makes it the most recently renewed.
- R13: After reset no line is reserved, resv_count_o and resv_valid_o are 0, and sc_done_o and sc_ok_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | 1 forces every store-conditional to pass |
| cmp_valid_i | input | 1 | A completion is presented this cycle |
| cmp_kind_i | input | 2 | 00 load, 01 load-linked, 10 store-conditional, 11 store |
| cmp_line_i | input | LINE_W | Line address of the completion |
| cmp_id_i | input | ID_W | Requester ID of the completion |
| inv_valid_i | input | 1 | Coherence permission lost for a line this cycle |
| inv_line_i | input | LINE_W | Line address that lost permission |
| sc_done_o | output | 1 | Registered pulse: a store-conditional verdict is present |
| sc_ok_o | output | 1 | Registered verdict, 1 passed, 0 failed |
| resv_valid_o | output | SLOTS | Registered occupancy of each reservation slot |
| resv_count_o | output | $clog2(SLOTS+1) | Registered number of reserved lines |

## Verification
Every result of this block comes from a register one edge behind the input. The verdict pair and the occupancy count for a completion presented before edge k are valid after edge k and hold until edge k+1. The bench drives each event on a falling edge and waits one rising edge. It compares the verdict and count at the next falling edge, before the next event is applied. Its reference model applies the events of a cycle in the order the requirements give: verdict first, then clears, then the new reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  // Completion kinds; the encoding is visible at the top-level port.
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_LL    = 2'b01,
    KIND_SC    = 2'b10,
    KIND_STORE = 2'b11
  } cmp_kind_e;

endpackage

// File: rtl/llsc_slot_cam.sv
// Parallel line-address comparison against every reservation slot.
module llsc_slot_cam #(
  parameter int SLOTS  = 4,
  parameter int LINE_W = 26
) (
  input  logic [SLOTS-1:0]             slot_live,
  input  logic [SLOTS-1:0][LINE_W-1:0] slot_line,
  input  logic [LINE_W-1:0]            key_line,
  output logic [SLOTS-1:0]             line_hit
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign line_hit[g] = slot_live[g] && (slot_line[g] == key_line);
  end

endmodule

// File: rtl/llsc_victim_sel.sv
// Picks the slot a load-linked writes: the slot already holding the line,
// else the lowest free slot, else the slot with the highest age.
// tgt_age returns the age the target held, or SLOTS when it was free.
module llsc_victim_sel #(
  parameter int SLOTS = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [SLOTS-1:0]            live,
  input  logic [SLOTS-1:0][CNT_W-1:0] age,
  input  logic [SLOTS-1:0]            hit,
  output logic [IDX_W-1:0]            tgt,
  output logic [CNT_W-1:0]            tgt_age
);

  logic [CNT_W-1:0] best_age;

  always_comb begin
    tgt      = '0;
    tgt_age  = CNT_W'(SLOTS);
    best_age = '0;
    if (|hit) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (hit[s]) begin
          tgt     = IDX_W'(s);
          tgt_age = age[s];
        end
      end
    end else if (!(&live)) begin
      for (int s = SLOTS - 1; s >= 0; s--) begin
        if (!live[s]) tgt = IDX_W'(s);
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (age[s] >= best_age) begin
          best_age = age[s];
          tgt      = IDX_W'(s);
        end
      end
      tgt_age = best_age;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bypass_i,
  input  logic                          cmp_valid_i,
  input  logic [1:0]                    cmp_kind_i,
  input  logic [LINE_W-1:0]             cmp_line_i,
  input  logic [ID_W-1:0]               cmp_id_i,
  input  logic                          inv_valid_i,
  input  logic [LINE_W-1:0]             inv_line_i,
  output logic                          sc_done_o,
  output logic                          sc_ok_o,
  output logic [SLOTS-1:0]              resv_valid_o,
  output logic [$clog2(SLOTS+1)-1:0]    resv_count_o
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  // Slot state: age 0 is the most recently set or renewed reservation.
  logic [SLOTS-1:0]             slot_v;
  logic [SLOTS-1:0][LINE_W-1:0] slot_line;
  logic [SLOTS-1:0][ID_W-1:0]   slot_id;
  logic [SLOTS-1:0][CNT_W-1:0]  slot_age;

  cmp_kind_e kind;
  logic      is_ll, is_sc, is_st;
  assign kind  = cmp_kind_e'(cmp_kind_i);
  assign is_ll = cmp_valid_i && (kind == KIND_LL);
  assign is_sc = cmp_valid_i && (kind == KIND_SC);
  assign is_st = cmp_valid_i && (kind == KIND_STORE);

  // Address matches for the completion and for the invalidation.
  logic [SLOTS-1:0] hit_cmp, hit_inv, id_eq, owned;

  llsc_slot_cam #(.SLOTS(SLOTS), .LINE_W(LINE_W)) i_cam_cmp (
    .slot_live (slot_v),
    .slot_line (slot_line),
    .key_line  (cmp_line_i),
    .line_hit  (hit_cmp)
  );

  llsc_slot_cam #(.SLOTS(SLOTS), .LINE_W(LINE_W)) i_cam_inv (
    .slot_live (slot_v),
    .slot_line (slot_line),
    .key_line  (inv_line_i),
    .line_hit  (hit_inv)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_owner
    assign id_eq[g] = (slot_id[g] == cmp_id_i);
  end
  assign owned = hit_cmp & id_eq;

  // Verdict uses the state before this cycle's clears (check first).
  logic sc_pass;
  assign sc_pass = |owned;

  // Clears from the completion and from the invalidation.
  logic [SLOTS-1:0] clr;
  always_comb begin
    clr = '0;
    if (is_sc)       clr = clr | hit_cmp;
    if (is_st)       clr = clr | owned;
    if (inv_valid_i) clr = clr | hit_inv;
  end

  // After clears: survivors keep their relative order, ages compacted.
  logic [SLOTS-1:0]            v_post;
  logic [SLOTS-1:0][CNT_W-1:0] age_post;
  logic [CNT_W-1:0]            dec_acc;
  assign v_post = slot_v & ~clr;

  always_comb begin
    age_post = slot_age;
    dec_acc  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      dec_acc = '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (clr[j] && slot_v[j] && (slot_age[j] < slot_age[s]))
          dec_acc = dec_acc + CNT_W'(1);
      end
      age_post[s] = slot_age[s] - dec_acc;
    end
  end

  // Target slot for a load-linked, chosen on the post-clear state.
  logic [SLOTS-1:0] hit_post;
  logic [IDX_W-1:0] tgt;
  logic [CNT_W-1:0] tgt_old;
  assign hit_post = hit_cmp & v_post;

  llsc_victim_sel #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_victim (
    .live    (v_post),
    .age     (age_post),
    .hit     (hit_post),
    .tgt     (tgt),
    .tgt_age (tgt_old)
  );

  // Next state.
  logic [SLOTS-1:0]             nxt_v;
  logic [SLOTS-1:0][LINE_W-1:0] nxt_line;
  logic [SLOTS-1:0][ID_W-1:0]   nxt_id;
  logic [SLOTS-1:0][CNT_W-1:0]  nxt_age;

  always_comb begin
    nxt_v    = v_post;
    nxt_line = slot_line;
    nxt_id   = slot_id;
    nxt_age  = age_post;
    if (is_ll) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (v_post[s] && (IDX_W'(s) != tgt) && (age_post[s] < tgt_old))
          nxt_age[s] = age_post[s] + CNT_W'(1);
      end
      nxt_v[tgt]    = 1'b1;
      nxt_line[tgt] = cmp_line_i;
      nxt_id[tgt]   = cmp_id_i;
      nxt_age[tgt]  = '0;
    end
  end

  logic [CNT_W-1:0] cnt_q;
  logic             done_q, ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v    <= '0;
      slot_line <= '0;
      slot_id   <= '0;
      slot_age  <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      slot_v    <= nxt_v;
      slot_line <= nxt_line;
      slot_id   <= nxt_id;
      slot_age  <= nxt_age;
      cnt_q     <= CNT_W'($countones(nxt_v));
      done_q    <= is_sc;
      ok_q      <= is_sc && (bypass_i || sc_pass);
    end
  end

  assign sc_done_o    = done_q;
  assign sc_ok_o      = ok_q;
  assign resv_valid_o = slot_v;
  assign resv_count_o = cnt_q;

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  assert_done_after_sc_R2: assert property (@(posedge clk) disable iff (rst)
    is_sc |=> sc_done_o);

  assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (rst)
    !is_sc |=> !sc_done_o);

  assert_ok_within_done_R3: assert property (@(posedge clk) disable iff (rst)
    sc_ok_o |-> sc_done_o);

  assert_bypass_passes_R10: assert property (@(posedge clk) disable iff (rst)
    (is_sc && bypass_i) |=> sc_ok_o);

  assert_ll_reserves_R1: assert property (@(posedge clk) disable iff (rst)
    is_ll |=> (resv_count_o != '0));

  // A second store-conditional right after one to the same line finds no
  // reservation: the first cleared it and nothing in between can set it.
  assert_sc_consumes_R4: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !bypass_i && $past(is_sc) && (cmp_line_i == $past(cmp_line_i)))
      |=> !sc_ok_o);

  // With all slots live, compacted ages must place a slot at SLOTS-1.
  assert_oldest_found_R9: assert property (@(posedge clk) disable iff (rst)
    (is_ll && (&v_post) && !(|hit_post)) |-> (tgt_old == CNT_W'(SLOTS - 1)));

endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;

  localparam int CLK_P  = 10;
  localparam int SLOTS  = 4;
  localparam int LINE_W = 26;
  localparam int ID_W   = 4;
  localparam int CNT_W  = $clog2(SLOTS + 1);

  localparam int K_LD = 0, K_LL = 1, K_SC = 2, K_ST = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 bypass_i = 1'b0;
  logic                 cmp_valid_i = 1'b0;
  logic [1:0]           cmp_kind_i = '0;
  logic [LINE_W-1:0]    cmp_line_i = '0;
  logic [ID_W-1:0]      cmp_id_i = '0;
  logic                 inv_valid_i = 1'b0;
  logic [LINE_W-1:0]    inv_line_i = '0;
  logic                 sc_done_o, sc_ok_o;
  logic [SLOTS-1:0]     resv_valid_o;
  logic [CNT_W-1:0]     resv_count_o;

  always #(CLK_P / 2) clk = ~clk;

  llsc_monitor #(.SLOTS(SLOTS), .LINE_W(LINE_W), .ID_W(ID_W)) i_llsc_monitor (
    .clk, .rst, .bypass_i, .cmp_valid_i, .cmp_kind_i, .cmp_line_i, .cmp_id_i,
    .inv_valid_i, .inv_line_i, .sc_done_o, .sc_ok_o, .resv_valid_o, .resv_count_o
  );

  int nvec = 0;
  int nerr = 0;

  // Reference model: entries ordered oldest first.
  int m_line [SLOTS];
  int m_id   [SLOTS];
  int m_n = 0;

  function automatic int m_find(input int line);
    for (int i = 0; i < m_n; i++) if (m_line[i] == line) return i;
    return -1;
  endfunction

  function automatic void m_drop(input int idx);
    if (idx < 0) return;
    for (int i = idx; i < m_n - 1; i++) begin
      m_line[i] = m_line[i + 1];
      m_id[i]   = m_id[i + 1];
    end
    m_n--;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmp_valid_i = 1'b0; inv_valid_i = 1'b0; bypass_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_n = 0;
    chk("R13 count", int'(resv_count_o), 0);
    chk("R13 valid", int'(resv_valid_o), 0);
    chk("R13 done",  int'(sc_done_o), 0);
    chk("R13 ok",    int'(sc_ok_o), 0);
  endtask

  // One event cycle: drive at a falling edge, compare at the next one.
  task automatic step(input string tag, input bit v, input int kind,
                      input int line, input int id, input bit iv,
                      input int iline, input bit byp);
    int  e_done, e_ok, own_i;
    bit  own;
    cmp_valid_i = v;
    cmp_kind_i  = 2'(kind);
    cmp_line_i  = LINE_W'(line);
    cmp_id_i    = ID_W'(id);
    inv_valid_i = iv;
    inv_line_i  = LINE_W'(iline);
    bypass_i    = byp;
    // verdict from state before this cycle
    own_i  = m_find(line);
    own    = (own_i >= 0) && (m_id[own_i] == id);
    e_done = (v && kind == K_SC) ? 1 : 0;
    e_ok   = (e_done == 1 && (byp || own)) ? 1 : 0;
    // clears
    if (v && kind == K_SC) m_drop(m_find(line));
    if (v && kind == K_ST && own) m_drop(m_find(line));
    if (iv) m_drop(m_find(iline));
    // new reservation
    if (v && kind == K_LL) begin
      m_drop(m_find(line));
      if (m_n == SLOTS) m_drop(0);
      m_line[m_n] = line;
      m_id[m_n]   = id;
      m_n++;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " done"},  int'(sc_done_o), e_done);
    chk({tag, " ok"},    int'(sc_ok_o), e_ok);
    chk({tag, " count"}, int'(resv_count_o), m_n);
    cmp_valid_i = 1'b0; inv_valid_i = 1'b0; bypass_i = 1'b0;
  endtask

  task automatic ev(input string tag, input int kind, input int line, input int id);
    step(tag, 1'b1, kind, line, id, 1'b0, 0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R1, R2, R3: reserve then pass
    ev("R1", K_LL, 1, 1);
    ev("R2", K_SC, 1, 1);
    // R4: a passed store-conditional consumed the reservation
    ev("R4", K_SC, 1, 1);
    // R4: failed one by another requester also clears
    ev("R1", K_LL, 2, 1);
    ev("R2", K_SC, 2, 2);
    ev("R4", K_SC, 2, 1);
    // R7: load-linked elsewhere keeps earlier reservation
    ev("R7", K_LL, 3, 1);
    ev("R7", K_LL, 4, 1);
    ev("R7", K_SC, 3, 1);
    ev("R4", K_SC, 4, 1);
    // R5: store by other requester is harmless, by owner clears
    ev("R5", K_LL, 5, 2);
    ev("R5", K_ST, 5, 1);
    ev("R5", K_SC, 5, 2);
    ev("R5", K_LL, 5, 2);
    ev("R5", K_ST, 5, 2);
    ev("R5", K_SC, 5, 2);
    // R6: invalidation clears
    ev("R6", K_LL, 6, 0);
    step("R6", 1'b0, K_LD, 0, 0, 1'b1, 6, 1'b0);
    ev("R6", K_SC, 6, 0);
    // R8: verdict before clear in the same cycle
    ev("R8", K_LL, 7, 0);
    step("R8", 1'b1, K_SC, 7, 0, 1'b1, 7, 1'b0);
    // R11: plain load has no effect
    ev("R11", K_LL, 8, 3);
    ev("R11", K_LD, 8, 0);
    ev("R11", K_SC, 8, 3);
    // R12: takeover by another requester
    ev("R12", K_LL, 9, 1);
    ev("R12", K_LL, 9, 2);
    ev("R12", K_SC, 9, 1);
    ev("R12", K_LL, 9, 1);
    ev("R12", K_LL, 9, 2);
    ev("R12", K_SC, 9, 2);

    // R9: replacement of the oldest
    do_reset();
    for (int i = 0; i < SLOTS; i++) ev("R9", K_LL, 10 + i, 0);
    ev("R9", K_LL, 20, 0);
    ev("R9", K_SC, 10, 0);
    ev("R9", K_SC, 11, 0);
    do_reset();
    for (int i = 0; i < SLOTS; i++) ev("R9", K_LL, 30 + i, 0);
    ev("R12", K_LL, 30, 0);
    ev("R9", K_LL, 40, 0);
    ev("R9", K_SC, 31, 0);
    ev("R9", K_SC, 30, 0);

    // R10: bypass passes, tracking continues
    step("R10", 1'b1, K_SC, 50, 0, 1'b0, 0, 1'b1);
    step("R10", 1'b1, K_LL, 51, 1, 1'b0, 0, 1'b1);
    ev("R10", K_SC, 51, 1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit v, iv, byp;
      int k, ln, id, il;
      v   = ($urandom % 4) != 0;
      k   = $urandom % 4;
      ln  = $urandom % 6;
      id  = $urandom % 3;
      iv  = ($urandom % 8) == 0;
      il  = $urandom % 6;
      byp = ($urandom % 10) == 0;
      step("R2 random", v, k, ln, id, iv, il, byp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule